// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a four-beat memory burst. When a new external address is captured, it keeps the upper address bits and takes the two lowest bits as the starting offset of the burst. After that, each clock with the step input asserted moves the two low bits to the next position in the burst order. A clock without a step is a wait cycle, and the address holds.

A static order input picks one of two burst orders. The interleaved order pairs offsets by XOR with a running beat count. The linear order counts upward and wraps modulo four. The block drives the merged word address and a two-bit beat index. The surrounding memory controller uses them to address the array for each beat.

Top module: `burst_seq_top`

## Requirements
- R1: A synchronous active-high reset clears the upper address, the start offset and the beat index, so `word_addr` and `beat_idx` read zero after the reset edge.
- R2: On a rising edge where either active-low strobe (`cpu_strobe_n` or `ctl_strobe_n`) is 0, the block captures `addr_in`. From the next cycle `word_addr` equals the captured address and `beat_idx` is 0.
- R3: On a rising edge with both strobes at 1 and `step_n` at 0, `beat_idx` increments by one, modulo 4.
- R4: On a rising edge with both strobes at 1 and `step_n` at 1, `beat_idx` and `word_addr` keep their values (wait cycle).
- R5: When `order_sel` is 1 (interleaved), `word_addr[1:0]` equals the start offset XOR `beat_idx`. For example, start 01 gives 01, 00, 11, 10.
- R6: When `order_sel` is 0 (linear), `word_addr[1:0]` equals (start offset + `beat_idx`) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R7: After four steps from a load, the low bits return to the start offset, and further steps repeat the same order.
- R8: When a strobe and a step are both asserted on the same edge, the load wins: `beat_idx` becomes 0 and the new address appears.
- R9: `word_addr[ADDR_W-1:2]` changes only on a load or a reset. Steps and waits leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_strobe_n | input | 1 | Address-capture strobe, active low |
| ctl_strobe_n | input | 1 | Second address-capture strobe, active low |
| step_n | input | 1 | Burst advance, active low; 1 means wait |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| addr_in | input | ADDR_W | External word address |
| word_addr | output | ADDR_W | Registered upper bits merged with the current offset |
| beat_idx | output | 2 | Beats advanced since the last load, mod 4 |

## Verification
The assertions assume that `order_sel` is static while a burst runs. The wait-cycle check therefore demands a stable address only across cycles in which the order input did not change. The offset checks rely on a start offset that the checker captures from the port whenever a strobe is low. The stimulus changes `order_sel` only just before a new load, so each burst runs entirely under one order. It also keeps every input free of X after reset.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int OFF_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic [OFF_W-1:0] start;
        logic [OFF_W-1:0] beat;
    } burst_state_t;

    function automatic logic [OFF_W-1:0] map_offset(
        input order_e           ord,
        input logic [OFF_W-1:0] start,
        input logic [OFF_W-1:0] beat
    );
        logic [OFF_W-1:0] res;
        if (ord == ORD_INTERLEAVE) begin
            res = start ^ beat;
        end else begin
            res = start + beat;
        end
        return res;
    endfunction

endpackage

// File: rtl/burst_upper_reg.sv
module burst_upper_reg #(
    parameter int UP_W = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [UP_W-1:0] upper_in,
    output logic [UP_W-1:0] upper_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
        end else if (load) begin
            upper_q <= upper_in;
        end
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [OFF_W-1:0] start_in,
    output burst_state_t     state_q
);

    burst_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.start = start_in;
            state_d.beat  = '0;
        end else if (step) begin
            state_d.beat  = state_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
    import burst_seq_pkg::*;
(
    input  order_e           ord,
    input  burst_state_t     state,
    output logic [OFF_W-1:0] offset
);

    always_comb begin
        offset = map_offset(ord, state.start, state.beat);
    end

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              step_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] word_addr,
    output logic [1:0]        beat_idx
);

    localparam int UP_W = ADDR_W - OFF_W;

    logic             load;
    logic             step;
    logic [UP_W-1:0]  upper_q;
    burst_state_t     state_q;
    logic [OFF_W-1:0] offset;
    order_e           ord;

    assign load = ~cpu_strobe_n | ~ctl_strobe_n;
    assign step = ~step_n;
    assign ord  = order_e'(order_sel);

    burst_upper_reg #(.UP_W(UP_W)) upper_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .upper_in (addr_in[ADDR_W-1:OFF_W]),
        .upper_q  (upper_q)
    );

    burst_beat_ctr beat_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .start_in (addr_in[OFF_W-1:0]),
        .state_q  (state_q)
    );

    burst_offset_map map_i (
        .ord    (ord),
        .state  (state_q),
        .offset (offset)
    );

    assign word_addr = {upper_q, offset};
    assign beat_idx  = state_q.beat;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_strobe_n,
    input logic              ctl_strobe_n,
    input logic              step_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] word_addr,
    input logic [1:0]        beat_idx
);

    logic [1:0] seen_start;
    logic       ld;

    assign ld = ~cpu_strobe_n | ~ctl_strobe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_start <= 2'd0;
        end else if (ld) begin
            seen_start <= addr_in[1:0];
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (word_addr == '0 && beat_idx == 2'd0));

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
        ld |=> (word_addr == $past(addr_in) && beat_idx == 2'd0));

    assert_step_incr_R3: assert property (@(posedge clk) disable iff (rst)
        (!ld && !step_n) |=> beat_idx == $past(beat_idx) + 2'd1);

    assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!ld && step_n) |=> ($stable(beat_idx) && (!$stable(order_sel) || $stable(word_addr))));

    assert_interleave_R5: assert property (@(posedge clk) disable iff (rst)
        order_sel |-> word_addr[1:0] == (seen_start ^ beat_idx));

    assert_linear_R6: assert property (@(posedge clk) disable iff (rst)
        !order_sel |-> word_addr[1:0] == 2'(seen_start + beat_idx));

    assert_upper_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(word_addr[ADDR_W-1:2]));

endmodule

bind burst_seq_top burst_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .step_n       (step_n),
    .order_sel    (order_sel),
    .addr_in      (addr_in),
    .word_addr    (word_addr),
    .beat_idx     (beat_idx)
);

// File: tb/burst_seq_top_tb_top.sv
`timescale 1ns/1ps
module burst_seq_top_tb_top;

    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          p_n = 1'b1;
    logic          c_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          ord = 1'b1;
    logic [AW-1:0] ain = '0;
    logic [AW-1:0] word_addr;
    logic [1:0]    beat_idx;

    int checks = 0;
    int fails  = 0;
    int m_start = 0;
    int m_beat  = 0;
    int m_upper = 0;

    always #5 clk = ~clk;

    burst_seq_top #(.ADDR_W(AW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .cpu_strobe_n (p_n),
        .ctl_strobe_n (c_n),
        .step_n       (adv_n),
        .order_sel    (ord),
        .addr_in      (ain),
        .word_addr    (word_addr),
        .beat_idx     (beat_idx)
    );

    function automatic int exp_off();
        if (ord) return m_start ^ m_beat;
        return (m_start + m_beat) % 4;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, model at the rising edge, compare at the next falling edge.
    task automatic cyc(bit r, bit pn, bit cn, bit an, int a);
        string tag;
        bit    ld;
        rst = r; p_n = pn; c_n = cn; adv_n = an; ain = a[AW-1:0];
        ld = !pn || !cn;
        @(posedge clk);
        if (r) begin
            m_start = 0; m_beat = 0; m_upper = 0;
        end else if (ld) begin
            m_start = a & 3; m_beat = 0; m_upper = (a >> 2) & 'h1fff;
        end else if (!an) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        if (r)       tag = "R1";
        else if (ld) tag = an ? "R2" : "R8";
        else if (an) tag = "R4";
        else         tag = ord ? "R5" : "R6";
        check(tag, int'(word_addr), (m_upper << 2) | exp_off());
        check(r ? "R1" : "R3", int'(beat_idx), m_beat);
    endtask

    // Load, then five steps with waits in between; checks wrap and upper stability.
    task automatic burst(int a, bit mode, bit use_ctl);
        int st;
        int up;
        ord = mode;
        st  = a & 3;
        up  = (a >> 2) & 'h1fff;
        cyc(0, use_ctl, !use_ctl, 1, a);
        for (int k = 0; k < 5; k++) begin
            cyc(0, 1, 1, 0, 0);
            check("R9", int'(word_addr[AW-1:2]), up);
            if (k == 1) cyc(0, 1, 1, 1, 'h7fff);
            if (k == 3) check("R7", int'(word_addr[1:0]), st);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(1, 1, 1, 1, 0);
        cyc(1, 1, 1, 1, 0);
        for (int m = 1; m >= 0; m--) begin
            for (int s = 0; s < 4; s++) begin
                burst('h1234 + s + (m * 'h2000), m[0], s[0]);
            end
        end
        // load wins over a simultaneous step (R8)
        ord = 1'b0;
        cyc(0, 0, 1, 1, 'h0556);
        cyc(0, 1, 1, 0, 0);
        cyc(0, 1, 0, 0, 'h6ab1);
        check("R8", int'(beat_idx), 0);
        cyc(0, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 'h7ffb);
        // long wait holds the address (R4)
        cyc(0, 1, 1, 0, 0);
        for (int w = 0; w < 3; w++) cyc(0, 1, 1, 1, 'h1111 * w);
        // reset mid burst (R1)
        cyc(1, 1, 1, 0, 0);
        check("R1", int'(word_addr), 0);
        cyc(0, 1, 1, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule